// File: doc/BRIEF.md
# GPIO Port Controller with Pin-Change Wake-up

This block controls an eight-pin general-purpose I/O port that a small processor reaches over a simple register bus with separate read and write strobes. Software writes a data latch and a direction register. For every pin the block drives an output-enable and an output value toward the pad cell, and it takes the pad's input level back in through a two-stage synchronizer.

Every pin has its own output drive style. It can drive both levels (push-pull), sink only (it pulls low and releases high), or source only (it pulls high and releases low). A read of the data register merges pad state and latch content bit by bit, chosen by direction. Software can therefore change one latch bit with a read-modify-write of the whole port and leave the other bits as they were.

Before the system sleeps, software pulses a sleep request. The block captures the synchronized inputs at that moment and arms a detector. From then on, a differing level on any pin set as an input raises a sticky wake-up request. Software clears the request, and disarms the detector, by writing one to a status bit.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, the direction register reads 0x00FF (all pins inputs), the data latch holds all ones, every pad_oe bit is 0, and wake_req is 0.
- R2: A direction bit of 1 makes its pin an input, with pad_oe low for that bit. A direction bit of 0 makes its pin an output, with drive set by its mode.
- R3: A read of the data register (offset 0) returns the synchronized pad level for each bit whose direction bit is 1, and the latch bit for each bit whose direction bit is 0. The unused upper bus bits read 0.
- R4: A write to the data register loads all latch bits, including those of input pins. A read, one bit changed, and a write back leave all other latch bits unchanged.
- R5: Mode code 00 (push-pull) on an output pin gives pad_oe=1 and pad_out equal to the latch bit. Mode code 11 behaves the same way.
- R6: Mode code 01 (sink only) on an output pin gives pad_out=0, with pad_oe=1 only while the latch bit is 0.
- R7: Mode code 10 (source only) on an output pin gives pad_out=1, with pad_oe=1 only while the latch bit is 1.
- R8: The mode register sits at offset 2, with pin i in bits [2i+1:2i], and reads back as written. The direction register sits at offset 1.
- R9: Once armed by a sleep_req pulse, wake_req rises when a synchronized input-direction pin differs from the level captured at the pulse. Differences on output-direction pins are ignored.
- R10: wake_req never rises while the detector is unarmed.
- R11: wake_req is sticky. Writing 1 to bit 0 of the status register (offset 3) clears it and disarms the detector, and writing 0 there has no effect. A status read returns the wake flag in bit 0 and the armed state in bit 1.
- R12: Read data appears on bus_rdata in the cycle after the one in which bus_rd is sampled high. Reads of offsets with no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| pad_in | input | WIDTH | Raw pad input levels |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output value |
| sleep_req | input | 1 | Pulse that captures inputs and arms wake-up |
| wake_req | output | 1 | Sticky wake-up request |

## Verification
The assertions assume that bus_wr and bus_rd are single-cycle strobes that are never high in the same cycle. They also assume that sleep_req is a one-cycle pulse and that pad_in changes no faster than the synchronizer can follow. The stimulus changes every input only on the falling clock edge, issues one access at a time, and holds pad levels for several cycles after each change. It waits for the wake flag only after the two synchronizer stages and the flag register have had time to settle.

// File: rtl/gpio_wake_pkg.sv
// Shared definitions for the GPIO wake-up port: drive mode codes and
// register offsets relative to the block's base address.
package gpio_wake_pkg;
    typedef enum logic [1:0] {
        DRV_PUSH   = 2'b00,
        DRV_SINK   = 2'b01,
        DRV_SOURCE = 2'b10,
        DRV_ALT    = 2'b11
    } drv_mode_e;

    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_DIR  = 1;
    localparam int unsigned OFS_MODE = 2;
    localparam int unsigned OFS_STAT = 3;
endpackage

// File: rtl/gpio_wake_sync.sv
// Multi-stage synchronizer for the raw pad inputs.
// Assumes: pad_in is asynchronous to clk. Each bit is synchronized on its
// own, with no bus coherency across bits.
module gpio_wake_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_wake_regs.sv
// Register file for the GPIO port: data latch, direction and drive mode,
// plus the status register. Reads are registered. Data read-back merges
// pad and latch per bit according to direction.
// Assumes: bus_wr and bus_rd are never high in the same cycle.
module gpio_wake_regs
    import gpio_wake_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int ADDR_W    = 4,
    parameter int BUS_W     = 16,
    parameter int BASE_ADDR = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [WIDTH-1:0]   pad_sync,
    input  logic               wake_flag,
    input  logic               wake_armed,
    output logic [WIDTH-1:0]   latch_q,
    output logic [WIDTH-1:0]   dir_q,
    output logic [2*WIDTH-1:0] mode_q,
    output logic               stat_clr
);
    localparam int MODE_W = 2 * WIDTH;
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BASE_ADDR + OFS_DIR);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BASE_ADDR + OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + OFS_STAT);

    logic             wr_data_sel, wr_dir_sel, wr_mode_sel;
    logic [WIDTH-1:0] port_view;
    logic [BUS_W-1:0] rd_mux;

    assign wr_data_sel = bus_wr && (bus_addr == A_DATA);
    assign wr_dir_sel  = bus_wr && (bus_addr == A_DIR);
    assign wr_mode_sel = bus_wr && (bus_addr == A_MODE);
    assign stat_clr    = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    // Data latch: loaded whole on a write, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           latch_q <= '1;
        else if (wr_data_sel) latch_q <= bus_wdata[WIDTH-1:0];
    end

    // Direction register: one means input, all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_q <= '1;
        else if (wr_dir_sel) dir_q <= bus_wdata[WIDTH-1:0];
    end

    // Drive mode register: two bits per pin, push-pull after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (wr_mode_sel) mode_q <= MODE_W'(bus_wdata);
    end

    // Per-bit read-back view: pad level for inputs, latch for outputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_view
        assign port_view[i] = dir_q[i] ? pad_sync[i] : latch_q[i];
    end

    // Read multiplexer over the register offsets; holes read zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_DATA:  rd_mux = BUS_W'(port_view);
            A_DIR:   rd_mux = BUS_W'(dir_q);
            A_MODE:  rd_mux = BUS_W'(mode_q);
            A_STAT:  rd_mux = BUS_W'({wake_armed, wake_flag});
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R4: the latch moves only on a write to the data offset.
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_DATA) |=> $stable(latch_q));

    // R12: read data changes only in the cycle after a read strobe.
    assert_rdata_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_wake_drive.sv
// Per-pin output stage: turns direction, drive mode and latch into the
// pad output enable and output value.
// Assumes: the pad cell drives pad_out only while pad_oe is high.
module gpio_wake_drive
    import gpio_wake_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   latch_q,
    input  logic [WIDTH-1:0]   dir_q,
    input  logic [2*WIDTH-1:0] mode_q,
    output logic [WIDTH-1:0]   pad_oe,
    output logic [WIDTH-1:0]   pad_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        drv_mode_e mode_i;
        assign mode_i = drv_mode_e'(mode_q[2*i +: 2]);

        // Decode the drive style of one pin into enable and level.
        always_comb begin
            pad_oe[i]  = 1'b0;
            pad_out[i] = latch_q[i];
            if (!dir_q[i]) begin
                case (mode_i)
                    DRV_SINK: begin
                        pad_oe[i]  = ~latch_q[i];
                        pad_out[i] = 1'b0;
                    end
                    DRV_SOURCE: begin
                        pad_oe[i]  = latch_q[i];
                        pad_out[i] = 1'b1;
                    end
                    default: begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = latch_q[i];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_wake_detect.sv
// Pin-change wake-up detector. A sleep pulse captures the synchronized
// inputs and arms the detector. While armed, any input-direction pin that
// differs from its captured level sets a sticky flag. A status clear drops
// both the flag and the armed state, and takes priority over a new set.
// Assumes: sleep_req is a single-cycle pulse.
module gpio_wake_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [WIDTH-1:0] pad_sync,
    input  logic [WIDTH-1:0] dir_q,
    input  logic             stat_clr,
    output logic             wake_flag,
    output logic             wake_armed
);
    logic [WIDTH-1:0] snap_q;
    logic             changed;

    assign changed = |((pad_sync ^ snap_q) & dir_q);

    // Snapshot of the input levels taken at sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (sleep_req) snap_q <= pad_sync;
    end

    // Armed state: set by a sleep pulse, dropped by a status clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         wake_armed <= 1'b0;
        else if (stat_clr)  wake_armed <= 1'b0;
        else if (sleep_req) wake_armed <= 1'b1;
    end

    // Sticky wake flag: set on a change while armed.
    always_ff @(posedge clk) begin
        if (!rst_n)                       wake_flag <= 1'b0;
        else if (stat_clr)                wake_flag <= 1'b0;
        else if (wake_armed && !sleep_req && changed) wake_flag <= 1'b1;
    end

    // R10: the flag can only rise out of the armed state.
    assert_wake_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(wake_armed));

    // R11: the flag holds until a status clear.
    assert_wake_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !stat_clr) |=> wake_flag);

    // R11: a status clear always drops the flag.
    assert_wake_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !wake_flag);
endmodule

// File: rtl/gpio_wake_port.sv
// Top of the GPIO port with pin-change wake-up: synchronizer, register
// file, output stage and wake detector.
// Assumes: a single-master bus with one-cycle strobes, and BUS_W at least
// 2*WIDTH so that the mode register fits one bus word.
module gpio_wake_port #(
    parameter int WIDTH     = 8,
    parameter int ADDR_W    = 4,
    parameter int BUS_W     = 2 * WIDTH,
    parameter int BASE_ADDR = 0,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    input  logic              sleep_req,
    output logic              wake_req
);
    localparam int MODE_W = 2 * WIDTH;

    logic [WIDTH-1:0]  pad_sync, latch_q, dir_q;
    logic [MODE_W-1:0] mode_q;
    logic              stat_clr, wake_flag, wake_armed;

    gpio_wake_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(pad_sync)
    );

    gpio_wake_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
                     .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_sync(pad_sync), .wake_flag(wake_flag), .wake_armed(wake_armed),
        .latch_q(latch_q), .dir_q(dir_q), .mode_q(mode_q), .stat_clr(stat_clr)
    );

    gpio_wake_drive #(.WIDTH(WIDTH)) u_drive (
        .latch_q(latch_q), .dir_q(dir_q), .mode_q(mode_q),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    gpio_wake_detect #(.WIDTH(WIDTH)) u_detect (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pad_sync(pad_sync),
        .dir_q(dir_q), .stat_clr(stat_clr),
        .wake_flag(wake_flag), .wake_armed(wake_armed)
    );

    assign wake_req = wake_flag;

    // R2: a pin set as input is never driven.
    assert_input_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    // R6: no pin in sink-only mode ever drives high.
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        assert_sink_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b01 && pad_oe[i]) |-> !pad_out[i]);
    end
endmodule

// File: tb/gpio_wake_port_bench.sv
// Scoreboard bench for the GPIO wake-up port.
module gpio_wake_port_bench;
    localparam int WIDTH  = 8;
    localparam int ADDR_W = 4;
    localparam int BUS_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0, sleep_req = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic [WIDTH-1:0]  pad_in = '0;
    logic [WIDTH-1:0]  pad_oe, pad_out;
    logic              wake_req;

    int checks = 0;
    int fails  = 0;
    logic [BUS_W-1:0] exp_q [$];
    string            tag_q [$];
    logic             mon_valid = 1'b0;

    gpio_wake_port u_gpio_wake_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .sleep_req(sleep_req), .wake_req(wake_req)
    );

    always #10 clk = ~clk;

    // Bench copy of "a read was sampled at this edge".
    always @(posedge clk) mon_valid <= bus_rd;

    // Monitor: pops the scoreboard when read data is due.
    always @(negedge clk) begin
        if (mon_valid) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R12: unexpected read data %h, expected none", bus_rdata);
            end else begin
                logic [BUS_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: read %h, expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected item.
    task automatic bus_read(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] e, string t);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(logic [15:0] act, logic [15:0] e, string t);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %h, expected %h", t, act, e);
        end
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: run hung, got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        pad_in = 8'hA5;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(16'(pad_oe), 16'h0000, "R1 oe");
        chk(16'(wake_req), 16'h0000, "R1 wake");
        bus_read(4'd1, 16'h00FF, "R1 dir");
        bus_read(4'd0, 16'h00A5, "R1 data reads pads");
        // R2/R3/R5: low nibble outputs, latch still ones
        bus_write(4'd1, 16'h00F0);
        chk(16'(pad_oe), 16'h000F, "R2 oe");
        chk(16'(pad_out & pad_oe), 16'h000F, "R5 out");
        bus_read(4'd0, 16'h00AF, "R3 mixed view");
        bus_write(4'd0, 16'h0030);
        chk(16'(pad_out & pad_oe), 16'h0000, "R5 out low");
        bus_read(4'd0, 16'h00A0, "R3 mixed view 2");
        // R4 read-modify-write of bit 1
        bus_write(4'd0, 16'h00A0 | 16'h0002);
        bus_read(4'd0, 16'h00A2, "R4 rmw");
        bus_write(4'd1, 16'h0000);
        bus_read(4'd0, 16'h00A2, "R4 latch all");
        chk(16'(pad_oe), 16'h00FF, "R2 all out");
        // R6/R7/R8 drive modes
        bus_write(4'd2, 16'h03A5);
        bus_read(4'd2, 16'h03A5, "R8 mode readback");
        chk(16'(pad_oe), 16'h00F1, "R6 R7 oe latch A2");
        chk(16'(pad_out[3:0]), 16'h000C, "R6 R7 out latch A2");
        chk(16'({pad_oe[4], pad_out[4]}), 16'h0002, "R5 mode 11");
        bus_write(4'd0, 16'h005D);
        chk(16'(pad_oe), 16'h00FE, "R6 R7 oe latch 5D");
        chk(16'(pad_out), 16'h005C, "R6 R7 out latch 5D");
        // R12 holes and status
        bus_read(4'd5, 16'h0000, "R12 hole");
        bus_read(4'd3, 16'h0000, "R11 status idle");
        // Wake-up: low nibble inputs
        bus_write(4'd1, 16'h000F);
        pad_in = 8'hA6;
        tick(5);
        chk(16'(wake_req), 16'h0000, "R10 unarmed");
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
        pad_in = 8'h56;
        tick(5);
        chk(16'(wake_req), 16'h0000, "R9 output pins ignored");
        pad_in = 8'h57;
        tick(5);
        chk(16'(wake_req), 16'h0001, "R9 wake");
        bus_read(4'd3, 16'h0003, "R11 status set");
        pad_in = 8'h56;
        tick(5);
        chk(16'(wake_req), 16'h0001, "R11 sticky");
        bus_write(4'd3, 16'h0000);
        tick(1);
        chk(16'(wake_req), 16'h0001, "R11 write zero");
        bus_write(4'd3, 16'h0001);
        chk(16'(wake_req), 16'h0000, "R11 clear");
        bus_read(4'd3, 16'h0000, "R11 disarmed");
        pad_in = 8'h50;
        tick(5);
        chk(16'(wake_req), 16'h0000, "R10 after clear");
        tick(3);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule